// File: doc/BRIEF.md
# Headset Button Debounce and Press Detector

This block conditions the raw level from a headset push button before software sees it. The button and headset-present inputs are asynchronous, so each is first brought into the system clock domain through two flops. The button level then goes through a glitch filter whose strength is set by a 2-bit select. The filter samples the level on a slow timebase derived from an external 1 ms tick. It accepts a new level only after eight consecutive samples all disagree with the current debounced level.

The select chooses the sample period, and the required run of samples stays at eight in every mode. A period of 1 ms gives an 8 ms window, 2 ms gives 16 ms and 4 ms gives 32 ms. A bypass setting forwards the synchronized level directly. Each rising edge of the debounced level is a press. A press sets a sticky flag that holds until a single-cycle status-read strobe clears it. A press that arrives in the same cycle as the read wins, so that no event is lost. The synchronized headset-present level is reported separately.

Top module: `hsbtn_detect`

## Requirements
- R1: While reset is asserted, and right after it is released, btn_db_o, press_flag_o and hs_det_o are 0. The select history resets to 00.
- R2: hs_raw_i reaches hs_det_o through two flops. A change on the input is still absent after one clock edge and visible after the second.
- R3: With db_sel_i = 2'b00 (bypass), btn_db_o takes the synchronized button level one clock after synchronization. A change on btn_raw_i is absent after two clock edges and present after three.
- R4: With db_sel_i = 2'b01, every tick_ms_i pulse is a sample. btn_db_o changes on the 8th consecutive sample that differs from it, and not on the 7th. Outside bypass, btn_db_o changes only on a clock edge where tick_ms_i is high.
- R5: With db_sel_i = 2'b10, the sample is taken on every 2nd tick counted from a restart. A steady new level is accepted after 16 ticks and not after 15.
- R6: With db_sel_i = 2'b11, the sample is taken on every 4th tick counted from a restart. A steady new level is accepted after 32 ticks and not after 31.
- R7: A sample that equals the current debounced level resets the run of disagreeing samples to zero.
- R8: press_flag_o rises on the same clock edge as btn_db_o rises, and at no other time.
- R9: Once set, press_flag_o stays 1 until a read strobe, including after the button is released.
- R10: A one-cycle stat_rd_i pulse clears press_flag_o on the following edge. A read with no pending press leaves the flag at 0.
- R11: If a press and a stat_rd_i pulse fall on the same clock edge, press_flag_o is 1 afterwards.
- R12: A change of db_sel_i restarts both the tick divider and the agreement run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_ms_i | input | 1 | One-cycle pulse every 1 ms |
| btn_raw_i | input | 1 | Raw asynchronous button level, 1 = pressed |
| hs_raw_i | input | 1 | Raw asynchronous headset-present level |
| db_sel_i | input | 2 | Debounce select: 00 bypass, 01 1 ms, 10 2 ms, 11 4 ms sampling |
| stat_rd_i | input | 1 | Single-cycle status-read strobe |
| btn_db_o | output | 1 | Debounced button level |
| press_flag_o | output | 1 | Sticky press flag, cleared by read |
| hs_det_o | output | 1 | Synchronized headset-detected level |

## Verification
The flag's set path and its clear path can meet on one clock edge: a rising debounced level and a status-read strobe. The bench provokes this in bypass mode. It places the read strobe on the exact edge where the synchronized rising button level reaches btn_db_o, which is the third edge after the input change. It judges the result by requiring press_flag_o to read 1 afterwards. A separate read with no press pending must leave the flag at 0.

// File: rtl/hsbtn_pkg.sv
package hsbtn_pkg;
  typedef enum logic [1:0] {
    DB_BYPASS = 2'b00,
    DB_DIV1   = 2'b01,
    DB_DIV2   = 2'b10,
    DB_DIV4   = 2'b11
  } db_sel_e;

  localparam int unsigned DIV_W   = 2;
  localparam int unsigned N_AGREE = 8;
endpackage

// File: rtl/hsbtn_sync.sv
module hsbtn_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hsbtn_sampler.sv
module hsbtn_sampler
  import hsbtn_pkg::*;
#(
  parameter int unsigned CNT_W = DIV_W
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  db_sel_e sel_i,
  input  logic    restart_i,
  output logic    sample_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    unique case (sel_i)
      DB_DIV2: mask = CNT_W'(1);
      DB_DIV4: mask = CNT_W'(3);
      default: mask = '0;
    endcase
  end

  assign sample_o = tick_i && (sel_i != DB_BYPASS) && !restart_i &&
                    ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || sel_i == DB_BYPASS) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hsbtn_filter.sv
module hsbtn_filter #(
  parameter int unsigned N_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic restart_i,
  input  logic sample_i,
  input  logic level_i,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(N_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(N_RUN - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (bypass_i) begin
      lvl_d = level_i;
      run_d = '0;
    end else if (restart_i) begin
      run_d = '0;
    end else if (sample_i) begin
      if (level_i != lvl_q) begin
        if (run_q == LAST) begin
          lvl_d = level_i;
          run_d = '0;
        end else begin
          run_d = run_q + CW'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_d & ~lvl_q;
endmodule

// File: rtl/hsbtn_flag.sv
module hsbtn_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set outranks clear so a press coinciding with a read survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hsbtn_detect.sv
module hsbtn_detect
  import hsbtn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_ms_i,
  input  logic       btn_raw_i,
  input  logic       hs_raw_i,
  input  logic [1:0] db_sel_i,
  input  logic       stat_rd_i,
  output logic       btn_db_o,
  output logic       press_flag_o,
  output logic       hs_det_o
);
  logic [1:0] raw_vec, sync_vec;
  db_sel_e    sel, sel_q;
  logic       restart, sample, rise;

  assign raw_vec = {hs_raw_i, btn_raw_i};
  assign sel     = db_sel_e'(db_sel_i);

  hsbtn_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= DB_BYPASS;
    else         sel_q <= sel;
  end

  assign restart = (sel != sel_q);

  hsbtn_sampler #(.CNT_W(DIV_W)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_ms_i),
    .sel_i    (sel),
    .restart_i(restart),
    .sample_o (sample)
  );

  hsbtn_filter #(.N_RUN(N_AGREE)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (sel == DB_BYPASS),
    .restart_i(restart),
    .sample_i (sample),
    .level_i  (sync_vec[0]),
    .level_o  (btn_db_o),
    .rise_o   (rise)
  );

  hsbtn_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (rise),
    .clr_i (stat_rd_i),
    .flag_o(press_flag_o)
  );

  assign hs_det_o = sync_vec[1];
endmodule

// File: rtl/hsbtn_detect_chk.sv
module hsbtn_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_ms_i,
  input logic [1:0] db_sel_i,
  input logic       stat_rd_i,
  input logic       btn_db_o,
  input logic       press_flag_o
);
  assert_db_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(db_sel_i) != 2'b00) && (btn_db_o != $past(btn_db_o))) |-> $past(tick_ms_i));

  assert_flag_with_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_db_o && !$past(btn_db_o)) |-> press_flag_o);

  assert_flag_only_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_flag_o && !$past(press_flag_o)) |-> (btn_db_o && !$past(btn_db_o)));

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_flag_o && !stat_rd_i) |=> press_flag_o);

  assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (!press_flag_o || $rose(btn_db_o)));
endmodule

bind hsbtn_detect hsbtn_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_ms_i   (tick_ms_i),
  .db_sel_i    (db_sel_i),
  .stat_rd_i   (stat_rd_i),
  .btn_db_o    (btn_db_o),
  .press_flag_o(press_flag_o)
);

// File: tb/hsbtn_detect_test.sv
module hsbtn_detect_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       btn = 1'b0;
  logic       hs = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       rd = 1'b0;
  logic       db, flag, hsdet;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  hsbtn_detect uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_ms_i   (tick),
    .btn_raw_i   (btn),
    .hs_raw_i    (hs),
    .db_sel_i    (sel),
    .stat_rd_i   (rd),
    .btn_db_o    (db),
    .press_flag_o(flag),
    .hs_det_o    (hsdet)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [5:0] nt;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b01, 6'd7,  1'b0},  // R4
    '{2'b01, 6'd8,  1'b1},  // R4
    '{2'b10, 6'd15, 1'b0},  // R5
    '{2'b10, 6'd16, 1'b1},  // R5
    '{2'b11, 6'd31, 1'b0},  // R6
    '{2'b11, 6'd32, 1'b1},  // R6
    '{2'b00, 6'd0,  1'b1}   // R3
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // three idle cycles first so input changes are synchronized before the sample
  task automatic ticks(input int n);
    repeat (n) begin
      cyc(3);
      tick = 1'b1;
      cyc(1);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    btn = 1'b0; hs = 1'b0; rd = 1'b0; tick = 1'b0; sel = 2'b00;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst_ni = 1'b0;
    btn = 1'b1; hs = 1'b1;
    cyc(3);
    chk("R1 db in reset", db, 1'b0);
    chk("R1 flag in reset", flag, 1'b0);
    chk("R1 hs in reset", hsdet, 1'b0);
    do_reset();
    chk("R1 db after reset", db, 1'b0);
    chk("R1 flag after reset", flag, 1'b0);

    for (int i = 0; i < 7; i++) begin
      do_reset();
      sel = VECS[i].sel;
      btn = 1'b1;
      cyc(4);
      ticks(int'(VECS[i].nt));
      chk($sformatf("R4/R5/R6 vec %0d db", i), db, VECS[i].exp);
      chk($sformatf("R8 vec %0d flag", i), flag, VECS[i].exp);
    end

    // R2 headset sync latency
    do_reset();
    hs = 1'b1;
    cyc(1);
    chk("R2 hs after one edge", hsdet, 1'b0);
    cyc(1);
    chk("R2 hs after two edges", hsdet, 1'b1);

    // R7 glitch restarts the agreement run
    do_reset();
    sel = 2'b01;
    btn = 1'b1;
    cyc(4);
    ticks(5);
    btn = 1'b0;
    ticks(1);
    btn = 1'b1;
    ticks(7);
    chk("R7 after glitch 7 samples", db, 1'b0);
    ticks(1);
    chk("R7 after glitch 8 samples", db, 1'b1);
    chk("R8 flag on press", flag, 1'b1);

    // R9 sticky through release
    btn = 1'b0;
    ticks(8);
    chk("R9 db released", db, 1'b0);
    chk("R9 flag held", flag, 1'b1);

    // R10 read clears, empty read stays clear
    read_pulse();
    chk("R10 flag cleared", flag, 1'b0);
    read_pulse();
    chk("R10 empty read", flag, 1'b0);

    // R12 select change restarts the run
    do_reset();
    sel = 2'b01;
    btn = 1'b1;
    cyc(4);
    ticks(5);
    sel = 2'b10;
    cyc(1);
    sel = 2'b01;
    cyc(4);
    ticks(7);
    chk("R12 run restarted", db, 1'b0);
    ticks(1);
    chk("R12 accepted after 8", db, 1'b1);

    // R3 bypass latency and R11 press colliding with read
    do_reset();
    cyc(4);
    btn = 1'b1;
    cyc(2);
    chk("R3 bypass not yet", db, 1'b0);
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    chk("R3 bypass level", db, 1'b1);
    chk("R11 press wins over read", flag, 1'b1);
    cyc(2);
    chk("R11 flag still held", flag, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule